// File: doc/BRIEF.md
# Receive Character Queue with Ageing Timer

This block sits on the receive side of a serial port, downstream of the bit deserializer. It takes each received character, with its parity-error, framing-error and break flags, and stores it in a 32-entry queue. A read port in the style of a register read hands out the oldest character on request, tagged with a valid marker. The port returns zero when nothing is stored.

Three live flags describe the queue. Receive-ready follows a programmable trigger level and changes only when a character is stored or read. Data-present and empty report whether anything is held. Three sticky status bits record events: overrun when a character is lost, break seen, and ageing when characters have been waiting below the trigger level for eight character times. The ageing count uses a once-per-bit tick, with ten ticks to a character. One interrupt line combines the enabled conditions.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds 32 characters. The fill level is taken after any read in the same cycle. A character offered while enabled when that level is 32 is dropped and sets the sticky overrun bit `sts_ovr`.
- R2: The stored word has data in bits 7:0, parity error in bit 8, framing error in bit 9, break in bit 10, overrun tag in bit 11 and error summary in bit 12. The overrun tag is set only on a character stored when 31 entries are in use. The error summary is the OR of bits 8 to 11.
- R3: After a cycle that stores a character, `rx_ready` is 1 if the new fill level is at or above the effective trigger level. The effective level is `trig_lvl`, except that 0 counts as 1.
- R4: After a cycle that reads a character, `rx_ready` is 0 if the new fill level is below the effective trigger level. `data_ready` is 1 and `fifo_empty` is 0 exactly while the fill level is non-zero.
- R5: A character offered while enabled with its break flag set sets the sticky `sts_brk` bit.
- R6: While `pop_req` is high, `pop_word` shows the oldest entry with bit 13 set, and that entry is removed at the clock edge. On an empty queue `pop_word` is 0 and no flag changes.
- R7: When `rx_en` is 0, offered characters are not stored and change no flag or status bit.
- R8: The ageing timer runs only while the queue is non-empty and `rx_ready` is 0. It restarts on every read and on every character offered while enabled. It sets the sticky `sts_age` bit on its 80th `baud_tick`, then stays idle until it restarts.
- R9: `irq` is the OR of four terms: `rx_ready` with `ien_ready`, `sts_age` with `ien_age`, `sts_ovr` with `ien_ovr`, and `data_ready` with `ien_drdy`.
- R10: `clr_ovr`, `clr_brk` and `clr_age` clear their sticky bits. A new set event in the same cycle wins over the clear.
- R11: After reset the queue is empty, `fifo_empty` is 1, and all other flags, status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| push_vld | input | 1 | A received character is offered this cycle |
| push_data | input | 8 | Character bits |
| push_perr | input | 1 | Parity error flag of the character |
| push_ferr | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| pop_req | input | 1 | Read strobe for the oldest character |
| pop_word | output | 14 | Read data: valid, error, overrun, break, framing, parity, data |
| trig_lvl | input | 6 | Receive-ready trigger level |
| baud_tick | input | 1 | One pulse per bit period |
| ien_ready | input | 1 | Interrupt enable for receive-ready |
| ien_age | input | 1 | Interrupt enable for ageing status |
| ien_ovr | input | 1 | Interrupt enable for overrun status |
| ien_drdy | input | 1 | Interrupt enable for data-present |
| clr_ovr | input | 1 | Write-one-to-clear strobe for overrun |
| clr_brk | input | 1 | Write-one-to-clear strobe for break |
| clr_age | input | 1 | Write-one-to-clear strobe for ageing |
| rx_ready | output | 1 | Fill level has reached the trigger level |
| data_ready | output | 1 | At least one character is held |
| fifo_empty | output | 1 | Queue is empty |
| sts_ovr | output | 1 | Sticky overrun |
| sts_brk | output | 1 | Sticky break seen |
| sts_age | output | 1 | Sticky ageing expiry |
| irq | output | 1 | Combined interrupt |

## Verification
Ageing expiry is the hardest condition to reach from the ports. It needs 80 bit ticks with no store and no read while the fill level stays below the trigger level. Uniform random traffic almost never leaves such a gap. The random stimulus therefore runs in phases, some with busy traffic and some with very rare stores and reads but frequent ticks, so that expiries happen often. Directed steps place one character and check the sticky bit after the 79th and after the 80th tick. A second directed case is a full queue with a read and a store in the same cycle. Another directed run fills past 32 entries to reach the in-band overrun tag and the dropped character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Trigger level with zero promoted to one.
  function automatic int eff_trigger(input int lvl);
    return (lvl == 0) ? 1 : lvl;
  endfunction

  // Stored word: {err, ovr_tag, brk, ferr, perr, data}.
  function automatic logic [12:0] pack_word(input logic [7:0] d, input logic perr,
                                            input logic ferr, input logic brk,
                                            input logic tag);
    return {(perr | ferr | brk | tag), tag, brk, ferr, perr, d};
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 13,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  assign head = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en |-> count < CNT_W'(DEPTH)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> count != '0); // R6
endmodule

// File: rtl/rxq_age.sv
module rxq_age #(
  parameter int LIMIT = 80,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic armed,
  input  logic tick,
  output logic hit
);
  logic [CW-1:0] ticks;
  logic          spent;

  assign hit = armed && !restart && tick && !spent && (ticks == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks <= '0;
      spent <= 1'b0;
    end else if (restart || !armed) begin
      ticks <= '0;
      spent <= 1'b0;
    end else if (hit) begin
      ticks <= '0;
      spent <= 1'b1;
    end else if (tick && !spent) begin
      ticks <= ticks + 1'b1;
    end
  end

  AST_AGE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> armed && !restart); // R8
  AST_AGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R8
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int CHAR_W       = 8,
  parameter int TL_W         = 6,
  parameter int BITS_PER_CHR = 10,
  parameter int AGE_CHARS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              push_vld,
  input  logic [CHAR_W-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop_req,
  output logic [CHAR_W+5:0] pop_word,
  input  logic [TL_W-1:0]   trig_lvl,
  input  logic              baud_tick,
  input  logic              ien_ready,
  input  logic              ien_age,
  input  logic              ien_ovr,
  input  logic              ien_drdy,
  input  logic              clr_ovr,
  input  logic              clr_brk,
  input  logic              clr_age,
  output logic              rx_ready,
  output logic              data_ready,
  output logic              fifo_empty,
  output logic              sts_ovr,
  output logic              sts_brk,
  output logic              sts_age,
  output logic              irq
);
  localparam int WORD_W = CHAR_W + 5;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int AGE_LIM = BITS_PER_CHR * AGE_CHARS;

  // Named internal events
  logic [CNT_W-1:0]  q_cnt, cnt_after_pop, cnt_next;
  logic [WORD_W-1:0] q_head, new_word;
  logic pop_ok, push_ev, push_acc, ovr_ev, tag_ev, brk_ev, age_hit, age_armed;
  logic ready_next;

  assign pop_ok        = pop_req && (q_cnt != '0);
  assign cnt_after_pop = q_cnt - CNT_W'(pop_ok);
  assign push_ev       = push_vld && rx_en;
  assign push_acc      = push_ev && (cnt_after_pop != CNT_W'(DEPTH));
  assign ovr_ev        = push_ev && (cnt_after_pop == CNT_W'(DEPTH));
  assign tag_ev        = push_acc && (cnt_after_pop == CNT_W'(DEPTH - 1));
  assign brk_ev        = push_ev && push_brk;
  assign cnt_next      = cnt_after_pop + CNT_W'(push_acc);
  assign new_word      = pack_word(push_data, push_perr, push_ferr, push_brk, tag_ev);

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_acc), .wr_word(new_word),
    .rd_en(pop_ok), .head(q_head), .count(q_cnt)
  );

  assign pop_word = pop_ok ? {1'b1, q_head} : '0;

  // Ready changes only on store or read events
  always_comb begin
    ready_next = rx_ready;
    if (int'(cnt_next) >= eff_trigger(int'(trig_lvl))) begin
      if (push_acc) ready_next = 1'b1;
    end else begin
      if (pop_ok) ready_next = 1'b0;
    end
  end

  assign age_armed = (q_cnt != '0) && !rx_ready;

  rxq_age #(.LIMIT(AGE_LIM)) u_age (
    .clk(clk), .rst_n(rst_n), .restart(push_ev || pop_ok), .armed(age_armed),
    .tick(baud_tick), .hit(age_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      sts_ovr  <= 1'b0;
      sts_brk  <= 1'b0;
      sts_age  <= 1'b0;
    end else begin
      rx_ready <= ready_next;
      sts_ovr  <= ovr_ev  || (sts_ovr && !clr_ovr);
      sts_brk  <= brk_ev  || (sts_brk && !clr_brk);
      sts_age  <= age_hit || (sts_age && !clr_age);
    end
  end

  assign data_ready = (q_cnt != '0);
  assign fifo_empty = (q_cnt == '0);
  assign irq = (rx_ready && ien_ready) || (sts_age && ien_age) ||
               (sts_ovr && ien_ovr) || (data_ready && ien_drdy);

  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(push_acc)); // R3
  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(pop_ok)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovr && !clr_ovr |=> sts_ovr); // R1
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_ovr) |-> $past(push_vld && rx_en)); // R1
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !pop_req |=> $stable(q_cnt)); // R7
  AST_AGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_age) |-> $past(age_armed && baud_tick)); // R8
endmodule

// File: tb/sim_rx_char_queue.sv
`timescale 1ns/1ps
module sim_rx_char_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, push_vld = 1'b0, push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic [7:0] push_data = '0;
  logic pop_req = 1'b0, baud_tick = 1'b0;
  logic [5:0] trig_lvl = '0;
  logic ien_ready = 0, ien_age = 0, ien_ovr = 0, ien_drdy = 0;
  logic clr_ovr = 0, clr_brk = 0, clr_age = 0;
  logic [13:0] pop_word;
  logic rx_ready, data_ready, fifo_empty, sts_ovr, sts_brk, sts_age, irq;

  always #2.5 clk = ~clk;

  rx_char_queue u0 (.*);

  int vecs = 0, errs = 0;
  logic [12:0] mq[$];
  bit m_ready, m_ovr, m_brk, m_age, m_spent;
  int m_acnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] ref_word(input logic [7:0] d, input bit pe, input bit fe,
                                           input bit bk, input bit tag);
    logic [12:0] w;
    w[7:0] = d; w[8] = pe; w[9] = fe; w[10] = bk; w[11] = tag;
    w[12] = pe || fe || bk || tag;
    return w;
  endfunction

  function automatic int trig_of(input logic [5:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  task automatic model_reset();
    mq.delete();
    m_ready = 0; m_ovr = 0; m_brk = 0; m_age = 0; m_spent = 0; m_acnt = 0;
  endtask

  task automatic check_flags();
    chk("R3/R4 rx_ready", rx_ready, m_ready);
    chk("R4 data_ready", data_ready, mq.size() != 0);
    chk("R4 fifo_empty", fifo_empty, mq.size() == 0);
    chk("R1 sts_ovr", sts_ovr, m_ovr);
    chk("R5 sts_brk", sts_brk, m_brk);
    chk("R8 sts_age", sts_age, m_age);
    chk("R9 irq", irq, (m_ready && ien_ready) || (m_age && ien_age) ||
                       (m_ovr && ien_ovr) || (mq.size() != 0 && ien_drdy));
  endtask

  task automatic step(input bit p, input logic [7:0] d, input bit pe, input bit fe,
                      input bit bk, input bit r, input bit tk,
                      input bit co, input bit cb, input bit ca);
    bit pop_ok, push_ev, acc, ovr_ev, tag, arm, hit, rdy_n;
    int eff;
    @(negedge clk);
    push_vld = p; push_data = d; push_perr = pe; push_ferr = fe; push_brk = bk;
    pop_req = r; baud_tick = tk; clr_ovr = co; clr_brk = cb; clr_age = ca;
    #1;
    if (r) chk("R6 pop_word", pop_word, (mq.size() == 0) ? 14'h0 : {1'b1, mq[0]});
    pop_ok  = r && mq.size() != 0;
    eff     = mq.size() - int'(pop_ok);
    push_ev = p && rx_en;
    acc     = push_ev && eff < 32;
    ovr_ev  = push_ev && eff == 32;
    tag     = acc && eff == 31;
    arm     = (mq.size() != 0) && !m_ready;
    hit     = 0;
    if (push_ev || pop_ok || !arm) begin
      m_acnt = 0; m_spent = 0;
    end else if (tk && !m_spent) begin
      if (m_acnt == 79) begin hit = 1; m_spent = 1; m_acnt = 0; end
      else m_acnt++;
    end
    if (pop_ok) void'(mq.pop_front());
    if (acc) mq.push_back(ref_word(d, pe, fe, bk, tag));
    rdy_n = m_ready;
    if (mq.size() >= trig_of(trig_lvl)) begin if (acc) rdy_n = 1; end
    else begin if (pop_ok) rdy_n = 0; end
    m_ready = rdy_n;
    m_ovr = ovr_ev || (m_ovr && !co);
    m_brk = (push_ev && bk) || (m_brk && !cb);
    m_age = hit || (m_age && !ca);
    @(posedge clk);
    #1;
    check_flags();
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tk, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset fifo_empty", fifo_empty, 1);
    chk("R11 reset data_ready", data_ready, 0);
    chk("R11 reset rx_ready", rx_ready, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset sts", {sts_ovr, sts_brk, sts_age}, 0);
    rst_n = 1;
  endtask

  bit done = 0;
  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errs++; vecs++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ien_ready = 1; ien_age = 1; ien_ovr = 1; ien_drdy = 1;
    do_reset();
    // R6: empty read gives zero, no change
    trig_lvl = 6'd40;
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R7: disabled receiver ignores characters, including break
    rx_en = 0;
    step(1, 8'h5A, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 ignored when disabled", {fifo_empty, sts_brk}, 2'b10);
    rx_en = 1;
    // R1/R2: fill past capacity
    for (int i = 0; i < 33; i++) step(1, 8'(i + 1), i == 3, i == 5, 0, 0, 0, 0, 0, 0);
    chk("R1 overrun after 33rd", sts_ovr, 1);
    // R1: full queue with read and store in the same cycle accepts the store
    step(1, 8'hEE, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R1 store with same-cycle read not dropped", sts_ovr, 0);
    for (int i = 0; i < 32; i++) begin
      if (i == 30) begin
        @(negedge clk); pop_req = 1; #1;
        chk("R2 tag on 32nd entry", pop_word[12:11], 2'b11);
        pop_req = 0;
      end
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    end
    // R8: ageing after exactly 80 ticks
    trig_lvl = 6'd4;
    step(1, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(79, 1);
    chk("R8 not yet at 79 ticks", sts_age, 0);
    idle(1, 1);
    chk("R8 set at 80 ticks", sts_age, 1);
    idle(100, 1);
    // R10: clear strobe, and set wins over clear
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 age cleared", sts_age, 0);
    step(1, 8'h22, 0, 0, 1, 0, 0, 0, 1, 0);
    chk("R10 break set wins over clear", sts_brk, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R3: trigger 0 behaves as 1
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    trig_lvl = 6'd0;
    step(1, 8'h33, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 trigger zero as one", rx_ready, 1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // Random phases
    for (int ph = 0; ph < 40; ph++) begin
      int pp, pr;
      bit quiet = (ph % 3 == 2);
      pp = quiet ? 1 : 20 + $urandom_range(0, 40);
      pr = quiet ? 1 : 20 + $urandom_range(0, 40);
      trig_lvl = 6'($urandom_range(0, 40));
      ien_ready = 1'($urandom); ien_age = 1'($urandom);
      ien_ovr = 1'($urandom); ien_drdy = 1'($urandom);
      rx_en = ($urandom_range(0, 9) != 0);
      for (int k = 0; k < 300; k++)
        step($urandom_range(0, 99) < pp, 8'($urandom), $urandom_range(0, 9) == 0,
             $urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
             $urandom_range(0, 99) < pr, $urandom_range(0, 3) != 0,
             $urandom_range(0, 49) == 0, $urandom_range(0, 49) == 0,
             $urandom_range(0, 49) == 0);
    end
    do_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule